// File: doc/BRIEF.md
# Tile-mapped pixel generator

This block turns the current scan position of a 640x480 raster into a 3-bit colour. The screen is not stored one bit per pixel. It is split into 8x8-pixel tiles, 80 across and 60 down. A tile store keeps one 5-bit pattern number for each of the 4800 tiles. A shared monochrome pattern ROM holds the 8x8 image of each of the 32 patterns. A set pattern bit paints white and a clear bit paints black. Blanking forces black.

A timing generator supplies the scan coordinates, the display-enable flag and a pixel enable tick. A host fills the tile store through a single synchronous write port. The display lookup uses two registered reads, first the tile store and then the pattern ROM. The low column bits, the enable flag and the tick travel alongside the reads. The output register then loads on the delayed tick, so the colour stays aligned with the pixel that was sampled.

Top module: `tile_pixel_gen`

## Requirements
- R1: The tile read for a scan position uses entry row*80 + col, where row = pixel_y[8:3] and col = pixel_x[9:3].
- R2: Pattern p of the ROM has a row byte for row r = pixel_y[2:0]. For p = 0 every byte is 0 (blank). For p != 0 the byte is the 8-bit value {p[4:0], r[2:0]}. Bit k of the byte is the pixel at pixel_x[2:0] = k, so bit 0 is the leftmost pixel.
- R3: A selected pattern bit of 1 gives rgb = 3'b111. A bit of 0 gives rgb = 3'b000.
- R4: When video_on is low with a tick, the resulting rgb is 3'b000, whatever the tile holds.
- R5: rgb loads only for an asserted pix_tick. The tick is sampled together with pixel_x, pixel_y and video_on, and the new colour appears after the third rising clock edge. Without a tick, rgb holds its value.
- R6: A write with wr_addr of 4800 or more changes no tile.
- R7: When a write and a display read hit the same tile in one cycle, the display sees the old pattern. Later reads see the new one.
- R8: After reset rgb is 3'b000, and every tile reads as pattern 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_tick | input | 1 | Pixel enable tick |
| video_on | input | 1 | Display-enable flag for the current scan position |
| pixel_x | input | 10 | Scan column |
| pixel_y | input | 10 | Scan line |
| wr_en | input | 1 | Tile store write strobe |
| wr_addr | input | 13 | Tile store write address |
| wr_idx | input | 5 | Pattern number to write |
| rgb | output | 3 | Registered colour |

## Verification
A tile entry that is wrong shows as a wrong colour at every pixel of that 8x8 square. That colour appears three edges after the tick that samples the square. A sideband delay that is out of step with the two reads shows up another way. The pattern bits land on the wrong pixel, or the blanking lands on the neighbour pixel, so the column-by-column checks against the stated row-byte formula catch it quickly. A failed reset of the written-flags shows as non-black pixels before any host write.

// File: rtl/tile_pkg.sv
package tile_pkg;
    localparam int unsigned COLS    = 80;
    localparam int unsigned ROWS    = 60;
    localparam int unsigned DEPTH   = COLS * ROWS;
    localparam int unsigned AW      = $clog2(DEPTH);
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned TPX     = 8;
    localparam int unsigned TSH     = $clog2(TPX);
    localparam int unsigned CRD_W   = 10;
    localparam logic [2:0]  FG_RGB  = 3'b111;
    localparam logic [2:0]  BG_RGB  = 3'b000;

    typedef struct packed {
        logic           s1_tick;
        logic           s1_von;
        logic [TSH-1:0] s1_col;
        logic           s2_tick;
        logic           s2_von;
        logic [TSH-1:0] s2_col;
        logic [2:0]     rgb;
    } pipe_t;

    function automatic logic [TPX-1:0] glyph_row(input logic [IDX_W-1:0] p,
                                                 input logic [TSH-1:0] r);
        if (p == '0) return '0;
        return TPX'({p, r});
    endfunction
endpackage

// File: rtl/tile_addr.sv
module tile_addr
    import tile_pkg::*;
(
    input  logic [CRD_W-1:0] px,
    input  logic [CRD_W-1:0] py,
    output logic [AW-1:0]    addr
);
    logic [CRD_W-TSH-1:0] row;
    logic [CRD_W-TSH-1:0] col;

    assign row = py[CRD_W-1:TSH];
    assign col = px[CRD_W-1:TSH];

    generate
        if (COLS == 80) begin : g_shift
            // row*80 = row*64 + row*16
            assign addr = (AW'(row) << 6) + (AW'(row) << 4) + AW'(col);
        end else begin : g_mult
            assign addr = AW'(row) * AW'(COLS) + AW'(col);
        end
    endgenerate
endmodule

// File: rtl/tile_store.sv
module tile_store
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]    rd_addr,
    output logic [IDX_W-1:0] rd_idx
);
    logic [IDX_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] written_q, written_d;
    logic [IDX_W-1:0] rd_idx_q, rd_idx_d;
    logic             wr_ok;

    assign wr_ok = wr_en && (wr_addr < AW'(DEPTH));

    always_comb begin
        written_d = written_q;
        if (wr_ok) written_d[wr_addr] = 1'b1;
        rd_idx_d = '0;
        if (rd_addr < AW'(DEPTH) && written_q[rd_addr])
            rd_idx_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            written_q <= '0;
            rd_idx_q  <= '0;
        end else begin
            written_q <= written_d;
            rd_idx_q  <= rd_idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_idx;
    end

    assign rd_idx = rd_idx_q;
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TSH-1:0]   row,
    output logic [TPX-1:0]   bits
);
    logic [TPX-1:0] bits_q, bits_d;

    always_comb bits_d = glyph_row(idx, row);

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    assign bits = bits_q;
endmodule

// File: rtl/tile_pixel_gen.sv
module tile_pixel_gen
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_tick,
    input  logic             video_on,
    input  logic [CRD_W-1:0] pixel_x,
    input  logic [CRD_W-1:0] pixel_y,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [2:0]       rgb
);
    pipe_t            p_q, p_d;
    logic [AW-1:0]    rd_addr;
    logic [IDX_W-1:0] tile_idx;
    logic [TSH-1:0]   row_q;
    logic [TPX-1:0]   row_bits;

    tile_addr u_addr (.px(pixel_x), .py(pixel_y), .addr(rd_addr));

    tile_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_idx(wr_idx), .rd_addr(rd_addr), .rd_idx(tile_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) row_q <= '0;
        else     row_q <= pixel_y[TSH-1:0];
    end

    glyph_rom u_rom (
        .clk(clk), .rst(rst), .idx(tile_idx), .row(row_q), .bits(row_bits)
    );

    always_comb begin
        p_d = p_q;
        p_d.s1_tick = pix_tick;
        p_d.s1_von  = video_on;
        p_d.s1_col  = pixel_x[TSH-1:0];
        p_d.s2_tick = p_q.s1_tick;
        p_d.s2_von  = p_q.s1_von;
        p_d.s2_col  = p_q.s1_col;
        if (p_q.s2_tick) begin
            if (!p_q.s2_von)                 p_d.rgb = BG_RGB;
            else if (row_bits[p_q.s2_col])   p_d.rgb = FG_RGB;
            else                             p_d.rgb = BG_RGB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign rgb = p_q.rgb;
endmodule

// File: rtl/tile_pixel_gen_chk.sv
module tile_pixel_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_tick,
    input logic       video_on,
    input logic [2:0] rgb
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assign warm = (age_q == 2'd3);

    // R5
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(pix_tick, 3)) |-> $stable(rgb));

    // R4
    blank_black_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(pix_tick, 3) && !$past(video_on, 3)) |-> (rgb == 3'b000));

    // R3
    two_colour_chk: assert property (@(posedge clk) disable iff (rst)
        (rgb == 3'b000) || (rgb == 3'b111));

    // R8
    reset_black_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rgb == 3'b000));
endmodule

bind tile_pixel_gen tile_pixel_gen_chk u_chk (
    .clk(clk), .rst(rst), .pix_tick(pix_tick), .video_on(video_on), .rgb(rgb)
);

// File: tb/sim_tile_pixel_gen.sv
`timescale 1ns/1ps
module sim_tile_pixel_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_tick = 1'b0;
    logic       video_on = 1'b0;
    logic [9:0] pixel_x = '0;
    logic [9:0] pixel_y = '0;
    logic       wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [4:0] wr_idx = '0;
    logic [2:0] rgb;

    int checks = 0;
    int errors = 0;
    int model [4800];

    always #2.5 clk = ~clk;

    tile_pixel_gen u0 (
        .clk(clk), .rst(rst), .pix_tick(pix_tick), .video_on(video_on),
        .pixel_x(pixel_x), .pixel_y(pixel_y), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_idx(wr_idx), .rgb(rgb)
    );

    function automatic logic [2:0] exp_rgb(int x, int y, bit von);
        int a, p, b;
        if (!von) return 3'b000;
        a = (y / 8) * 80 + (x / 8);
        p = model[a];
        if (p == 0) return 3'b000;
        b = (p * 8) + (y % 8);
        return ((b >> (x % 8)) & 1) ? 3'b111 : 3'b000;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: rgb=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic host_write(int a, int idx);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 13'(a); wr_idx = 5'(idx);
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4800) model[a] = idx;
    endtask

    // present one pixel with a tick, wait for three edges, compare
    task automatic show(string req, int x, int y, bit von);
        logic [2:0] e;
        e = exp_rgb(x, y, von);
        @(negedge clk);
        pixel_x = 10'(x); pixel_y = 10'(y); video_on = von; pix_tick = 1'b1;
        @(negedge clk);
        pix_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(req, rgb, e);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: rgb=%b expected=done", rgb);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] held, e_old;
        int seed_dummy;
        seed_dummy = $urandom(1234);
        for (int i = 0; i < 4800; i++) model[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset rgb", rgb, 3'b000);
        show("R8 unwritten tile blank", 100, 200, 1'b1);
        show("R8 unwritten tile 0", 3, 0, 1'b1);

        // R2 R3: pattern 31 at tile 0, scan all columns of two rows
        host_write(0, 31);
        for (int x = 0; x < 8; x++) show("R2 R3 pattern columns", x, 0, 1'b1);
        for (int x = 0; x < 8; x++) show("R2 pattern row 5", x, 5, 1'b1);

        // R1: far corner tile 4799 and a mid tile
        host_write(4799, 21);
        for (int x = 632; x < 640; x++) show("R1 last tile", x, 477, 1'b1);
        host_write(13 * 80 + 47, 9);
        for (int x = 376; x < 384; x++) show("R1 mid tile", x, 106, 1'b1);
        show("R1 neighbour tile untouched", 384, 106, 1'b1);

        // R4: blanking over a lit pixel
        show("R4 blank forces black", 7, 7, 1'b0);

        // R5: no tick keeps rgb
        show("R5 lit", 7, 7, 1'b1);
        held = rgb;
        @(negedge clk);
        pixel_x = 10'd0; pixel_y = 10'd1; video_on = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 hold without tick", rgb, held);

        // R6: out-of-range writes
        host_write(4800, 7);
        host_write(8191, 7);
        show("R6 tile 0 intact", 0, 0, 1'b1);
        show("R6 tile 4799 intact", 639, 479, 1'b1);
        show("R6 tile 1 untouched", 8, 0, 1'b1);

        // R7: write and display read same cycle
        host_write(2, 0);
        e_old = exp_rgb(16 + 3, 0, 1'b1);
        @(negedge clk);
        pixel_x = 10'd19; pixel_y = 10'd0; video_on = 1'b1; pix_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 13'd2; wr_idx = 5'd31;
        @(negedge clk);
        pix_tick = 1'b0; wr_en = 1'b0; model[2] = 31;
        @(negedge clk);
        @(negedge clk);
        check("R7 old value on collision", rgb, e_old);
        show("R7 new value afterwards", 19, 0, 1'b1);

        // random fill and random scan
        for (int i = 0; i < 300; i++)
            host_write($urandom_range(0, 4799), $urandom_range(0, 31));
        for (int i = 0; i < 1500; i++)
            show("R1 R2 R3 R4 random", $urandom_range(0, 639),
                 $urandom_range(0, 479), ($urandom_range(0, 7) != 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule